// File: doc/BRIEF.md
# Time Slot Switch Processor Port

This block is the parallel host port of a time slot switch. A host reaches it through a 6-bit address, an 8-bit data bus and single-cycle read and write strobes. An 8-bit control byte is stored here and split into fields for the switch core: which memory the host window targets, which stream that window covers, a split mode and a processor-enable flag.

The block also holds the two connection memories, a low byte and a high byte for each output channel, plus the data memory. The host reaches all three through a 32-byte window. Address bit 5 picks between the control byte and the window, and bits 4..0 pick a channel. The selected stream, taken from the control byte, supplies the upper part of the memory index.

The switch core fills the data memory through its own write port. It reads both connection memories for one channel through a registered read port. From the host side the data memory is read-only. In split mode, window reads come from the data memory while window writes still go to the connection memory that the select field names.

Top module: `tsi_cpu_port`

## Requirements
- R1: After reset, the control byte is 0x00, so `mem_sel_o`, `stream_o`, `split_o` and `pe_o` are all zero, and `rvalid_o` is low.
- R2: A write with `addr_i[5]`=0 stores `wdata_i` in the control byte whatever `addr_i[4:0]` holds. A read with `addr_i[5]`=0 returns all 8 stored bits, including unused bits 5 and 2.
- R3: The control byte fields reach the ports on the cycle after the write. Bit 7 drives `split_o`, bit 6 drives `pe_o`, bits 4:3 drive `mem_sel_o` and bits 1:0 drive `stream_o`. Without a control write these fields do not change.
- R4: With select code 10 (connection low), a window write to channel c stores the byte at index stream*32+c of the low memory. The core sees it on `cml_o` one cycle after it presents that index on `cm_raddr_i`.
- R5: With select code 11 (connection high), a window write stores the byte at index stream*32+c of the high memory. It is seen on `cmh_o` in the same way.
- R6: With split off, a window read returns the byte at stream*32+c of the selected memory. Code 00 selects the data memory, 10 the low memory and 11 the high memory.
- R7: Select code 01 is reserved. A window read under it returns 0x00 when split is off, and a window write under it changes no memory.
- R8: A window write under select code 00 is dropped, so the data memory keeps what the core wrote.
- R9: With split on, window reads return data memory contents whatever the select code. Window writes still go to the connection memory named by the select code.
- R10: `rvalid_o` is high for exactly the cycle after each read strobe, and `rdata_o` is valid in that cycle. When a read and a write arrive in the same cycle, the read returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 6 | Host address; bit 5 selects the window |
| wdata_i | input | 8 | Host write data |
| wr_i | input | 1 | Host write strobe, one cycle |
| rd_i | input | 1 | Host read strobe, one cycle |
| rdata_o | output | 8 | Host read data |
| rvalid_o | output | 1 | Read data valid |
| mem_sel_o | output | 2 | Memory select field |
| stream_o | output | 2 | Stream field of the window |
| split_o | output | 1 | Split mode |
| pe_o | output | 1 | Processor enable to the core |
| dm_we_i | input | 1 | Core write enable, data memory |
| dm_waddr_i | input | 7 | Core write index, data memory |
| dm_wdata_i | input | 8 | Core write data, data memory |
| cm_raddr_i | input | 7 | Core read index, connection memories |
| cml_o | output | 8 | Connection low byte for `cm_raddr_i` |
| cmh_o | output | 8 | Connection high byte for `cm_raddr_i` |

## Verification
A corrupted control byte shows on the exported fields in the very next cycle, and the next window access then lands on the wrong memory or stream. A decode error that sends a write to the wrong memory stays hidden until that location is read back, either by the host one cycle after its strobe or by the core one cycle after it presents the index. For this reason each write is paired with a read-back through both paths, and the reserved and data-memory codes are also checked to leave earlier contents intact.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 6;
  localparam int CH_W   = 5;

  typedef enum logic [1:0] {
    MSEL_DM  = 2'b00,
    MSEL_RSV = 2'b01,
    MSEL_CML = 2'b10,
    MSEL_CMH = 2'b11
  } msel_e;

  typedef enum logic [2:0] {
    TGT_NONE = 3'd0,
    TGT_CTRL = 3'd1,
    TGT_DM   = 3'd2,
    TGT_CML  = 3'd3,
    TGT_CMH  = 3'd4
  } tgt_e;
endpackage

// File: rtl/tsi_ctrl_reg.sv
module tsi_ctrl_reg
  import tsi_pkg::*;
#(
  parameter int STREAM_W = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   ctrl_o,
  output logic                split_o,
  output logic                pe_o,
  output logic [1:0]          msel_o,
  output logic [STREAM_W-1:0] stream_o
);
  logic [DATA_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= '0;
    else if (we_i) ctrl_q <= wdata_i;
  end

  assign ctrl_o   = ctrl_q;
  assign split_o  = ctrl_q[7];
  assign pe_o     = ctrl_q[6];
  assign msel_o   = ctrl_q[4:3];
  assign stream_o = ctrl_q[STREAM_W-1:0];
endmodule

// File: rtl/tsi_addr_decode.sv
module tsi_addr_decode
  import tsi_pkg::*;
#(
  parameter int STREAM_W = 2,
  localparam int IDX_W   = STREAM_W + CH_W
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic                split_i,
  input  logic [1:0]          msel_i,
  input  logic [STREAM_W-1:0] stream_i,
  output tgt_e                wr_tgt_o,
  output tgt_e                rd_tgt_o,
  output logic [IDX_W-1:0]    idx_o
);
  logic win;
  assign win   = addr_i[ADDR_W-1];
  assign idx_o = {stream_i, addr_i[CH_W-1:0]};

  always_comb begin
    wr_tgt_o = TGT_NONE;
    if (wr_i) begin
      if (!win) wr_tgt_o = TGT_CTRL;
      else begin
        unique case (msel_e'(msel_i))
          MSEL_CML: wr_tgt_o = TGT_CML;
          MSEL_CMH: wr_tgt_o = TGT_CMH;
          default:  wr_tgt_o = TGT_NONE; // data memory read-only, code 01 reserved
        endcase
      end
    end
  end

  always_comb begin
    rd_tgt_o = TGT_NONE;
    if (rd_i) begin
      if (!win)         rd_tgt_o = TGT_CTRL;
      else if (split_i) rd_tgt_o = TGT_DM;
      else begin
        unique case (msel_e'(msel_i))
          MSEL_DM:  rd_tgt_o = TGT_DM;
          MSEL_CML: rd_tgt_o = TGT_CML;
          MSEL_CMH: rd_tgt_o = TGT_CMH;
          default:  rd_tgt_o = TGT_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/tsi_byte_ram.sv
module tsi_byte_ram #(
  parameter int DW    = 8,
  parameter int IDX_W = 7,
  parameter int N_RD  = 1,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic                       clk_i,
  input  logic                       we_i,
  input  logic [IDX_W-1:0]           waddr_i,
  input  logic [DW-1:0]              wdata_i,
  input  logic [N_RD-1:0][IDX_W-1:0] raddr_i,
  output logic [N_RD-1:0][DW-1:0]    rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  for (genvar g = 0; g < N_RD; g++) begin : g_rd
    assign rdata_o[g] = mem[raddr_i[g]];
  end
endmodule

// File: rtl/tsi_cpu_port.sv
module tsi_cpu_port
  import tsi_pkg::*;
#(
  parameter int STREAM_W = 2,
  localparam int IDX_W   = STREAM_W + CH_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                wr_i,
  input  logic                rd_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                rvalid_o,
  output logic [1:0]          mem_sel_o,
  output logic [STREAM_W-1:0] stream_o,
  output logic                split_o,
  output logic                pe_o,
  input  logic                dm_we_i,
  input  logic [IDX_W-1:0]    dm_waddr_i,
  input  logic [DATA_W-1:0]   dm_wdata_i,
  input  logic [IDX_W-1:0]    cm_raddr_i,
  output logic [DATA_W-1:0]   cml_o,
  output logic [DATA_W-1:0]   cmh_o
);
  logic [DATA_W-1:0] ctrl;
  tgt_e              wr_tgt, rd_tgt;
  logic [IDX_W-1:0]  idx;

  logic [0:0][DATA_W-1:0] dm_rd;
  logic [1:0][DATA_W-1:0] cml_rd, cmh_rd;

  tsi_ctrl_reg #(.STREAM_W(STREAM_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_tgt == TGT_CTRL),
    .wdata_i (wdata_i),
    .ctrl_o  (ctrl),
    .split_o (split_o),
    .pe_o    (pe_o),
    .msel_o  (mem_sel_o),
    .stream_o(stream_o)
  );

  tsi_addr_decode #(.STREAM_W(STREAM_W)) u_dec (
    .addr_i  (addr_i),
    .wr_i    (wr_i),
    .rd_i    (rd_i),
    .split_i (split_o),
    .msel_i  (mem_sel_o),
    .stream_i(stream_o),
    .wr_tgt_o(wr_tgt),
    .rd_tgt_o(rd_tgt),
    .idx_o   (idx)
  );

  tsi_byte_ram #(.DW(DATA_W), .IDX_W(IDX_W), .N_RD(1)) u_dm (
    .clk_i  (clk_i),
    .we_i   (dm_we_i),
    .waddr_i(dm_waddr_i),
    .wdata_i(dm_wdata_i),
    .raddr_i(idx),
    .rdata_o(dm_rd)
  );

  // port 0: host window, port 1: core
  tsi_byte_ram #(.DW(DATA_W), .IDX_W(IDX_W), .N_RD(2)) u_cml (
    .clk_i  (clk_i),
    .we_i   (wr_tgt == TGT_CML),
    .waddr_i(idx),
    .wdata_i(wdata_i),
    .raddr_i({cm_raddr_i, idx}),
    .rdata_o(cml_rd)
  );

  tsi_byte_ram #(.DW(DATA_W), .IDX_W(IDX_W), .N_RD(2)) u_cmh (
    .clk_i  (clk_i),
    .we_i   (wr_tgt == TGT_CMH),
    .waddr_i(idx),
    .wdata_i(wdata_i),
    .raddr_i({cm_raddr_i, idx}),
    .rdata_o(cmh_rd)
  );

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    unique case (rd_tgt)
      TGT_CTRL: rd_mux = ctrl;
      TGT_DM:   rd_mux = dm_rd[0];
      TGT_CML:  rd_mux = cml_rd[0];
      TGT_CMH:  rd_mux = cmh_rd[0];
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
      cml_o    <= '0;
      cmh_o    <= '0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) rdata_o <= rd_mux;
      cml_o <= cml_rd[1];
      cmh_o <= cmh_rd[1];
    end
  end
endmodule

// File: rtl/tsi_cpu_port_chk.sv
module tsi_cpu_port_chk #(
  parameter int STREAM_W = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [5:0]          addr_i,
  input logic [7:0]          wdata_i,
  input logic                wr_i,
  input logic                rd_i,
  input logic [7:0]          rdata_o,
  input logic                rvalid_o,
  input logic [1:0]          mem_sel_o,
  input logic [STREAM_W-1:0] stream_o,
  input logic                split_o,
  input logic                pe_o
);
  a_r10_rvalid_after_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_o);

  a_r10_no_spurious_rvalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !rvalid_o);

  a_r3_fields_follow_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !addr_i[5]) |=> (split_o == $past(wdata_i[7]) && pe_o == $past(wdata_i[6])
                              && mem_sel_o == $past(wdata_i[4:3])
                              && stream_o == $past(wdata_i[STREAM_W-1:0])));

  a_r3_fields_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && !addr_i[5]) |=> $stable({split_o, pe_o, mem_sel_o, stream_o}));

  a_r7_reserved_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i[5] && !split_o && mem_sel_o == 2'b01) |=> rdata_o == 8'h00);
endmodule

bind tsi_cpu_port tsi_cpu_port_chk #(.STREAM_W(STREAM_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .wr_i     (wr_i),
  .rd_i     (rd_i),
  .rdata_o  (rdata_o),
  .rvalid_o (rvalid_o),
  .mem_sel_o(mem_sel_o),
  .stream_o (stream_o),
  .split_o  (split_o),
  .pe_o     (pe_o)
);

// File: tb/sim_tsi_cpu_port.sv
module sim_tsi_cpu_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] rdata;
  logic       rvalid;
  logic [1:0] msel, stream;
  logic       split, pe;
  logic       dm_we = 1'b0;
  logic [6:0] dm_waddr = '0, cm_raddr = '0;
  logic [7:0] dm_wdata = '0, cml, cmh;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] ctrl_m = 8'h00;

  always #10 clk = ~clk;

  tsi_cpu_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr), .rd_i(rd),
    .rdata_o(rdata), .rvalid_o(rvalid), .mem_sel_o(msel), .stream_o(stream),
    .split_o(split), .pe_o(pe), .dm_we_i(dm_we), .dm_waddr_i(dm_waddr),
    .dm_wdata_i(dm_wdata), .cm_raddr_i(cm_raddr), .cml_o(cml), .cmh_o(cmh)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected read data as rvalid appears
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) check("R10 spurious rvalid", 8'h01, 8'h00);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic bus_wr(logic [5:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    if (!a[5]) ctrl_m = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(logic [5:0] a, logic [7:0] e, string req);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(req);
    addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic dm_put(logic [6:0] i, logic [7:0] d);
    @(negedge clk); dm_waddr = i; dm_wdata = d; dm_we = 1'b1;
    @(negedge clk); dm_we = 1'b0;
  endtask

  task automatic cm_peek(logic [6:0] i, output logic [7:0] lo, output logic [7:0] hi);
    @(negedge clk); cm_raddr = i;
    @(negedge clk); lo = cml; hi = cmh;
  endtask

  task automatic fields(string req);
    check({req, " split"},  {7'd0, split}, {7'd0, ctrl_m[7]});
    check({req, " pe"},     {7'd0, pe},    {7'd0, ctrl_m[6]});
    check({req, " msel"},   {6'd0, msel},  {6'd0, ctrl_m[4:3]});
    check({req, " stream"}, {6'd0, stream},{6'd0, ctrl_m[1:0]});
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] lo, hi;
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 rvalid", {7'd0, rvalid}, 8'h00);
    fields("R1");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 no rvalid idle", {7'd0, rvalid}, 8'h00);

    // R2/R3: low address bits ignored, readback incl. unused bits
    bus_wr(6'h1F, 8'hA5);
    fields("R3");
    bus_rd(6'h0A, 8'hA5, "R2 ctrl readback");

    // R4: low connection memory, stream 1
    bus_wr(6'h00, 8'h11);
    fields("R3");
    bus_wr(6'h23, 8'h3C);
    bus_wr(6'h3F, 8'hE1);
    cm_peek(7'd35, lo, hi); check("R4 cml[35]", lo, 8'h3C);
    cm_peek(7'd63, lo, hi); check("R4 cml[63]", lo, 8'hE1);
    bus_rd(6'h23, 8'h3C, "R6 read cml");
    bus_rd(6'h3F, 8'hE1, "R6 read cml ch31");

    // R5: high connection memory, stream 2
    bus_wr(6'h00, 8'h1A);
    bus_wr(6'h20, 8'h77);
    cm_peek(7'd64, lo, hi); check("R5 cmh[64]", hi, 8'h77);
    bus_rd(6'h20, 8'h77, "R6 read cmh");

    // R6/R8: data memory window
    dm_put(7'd35, 8'h5A);
    dm_put(7'd103, 8'hC3);
    bus_wr(6'h00, 8'h03);
    bus_rd(6'h27, 8'hC3, "R6 read dm");
    bus_wr(6'h27, 8'hFF);
    bus_rd(6'h27, 8'hC3, "R8 dm write dropped");
    cm_peek(7'd103, lo, hi);
    bus_wr(6'h00, 8'h1B);
    bus_rd(6'h27, hi, "R8 cmh untouched by dm write");

    // R7: reserved code
    bus_wr(6'h00, 8'h09);
    bus_rd(6'h23, 8'h00, "R7 reserved read");
    bus_wr(6'h23, 8'h99);
    cm_peek(7'd35, lo, hi); check("R7 cml untouched", lo, 8'h3C);
    bus_wr(6'h00, 8'h11);
    bus_rd(6'h23, 8'h3C, "R7 cml readback");

    // R9: split mode
    bus_wr(6'h00, 8'h91);
    fields("R3");
    bus_rd(6'h23, 8'h5A, "R9 split read dm");
    bus_wr(6'h23, 8'h42);
    cm_peek(7'd35, lo, hi); check("R9 split write cml", lo, 8'h42);
    bus_wr(6'h00, 8'h11);
    bus_rd(6'h23, 8'h42, "R9 cml after split");

    // R3: processor enable
    bus_wr(6'h00, 8'h40);
    fields("R3");

    // R10: read and write in the same cycle return old contents
    @(negedge clk);
    exp_q.push_back(8'h40); tag_q.push_back("R10 read-before-write");
    addr = 6'h05; wdata = 8'h66; wr = 1'b1; rd = 1'b1; ctrl_m = 8'h66;
    @(negedge clk); wr = 1'b0; rd = 1'b0;
    bus_rd(6'h00, 8'h66, "R10 new value");

    repeat (3) @(negedge clk);
    check("R10 queue drained", 8'(exp_q.size()), 8'h00);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule